// File: doc/BRIEF.md
# Latched Half-Bridge Fault Protector

This block keeps the fault latch of a half-bridge lamp driver. It watches three comparator flags on every clock: an over-current flag and an under-current flag, both taken from the half-bridge current sense, and an over-temperature flag. The mode sequencer arms each check at its own phase. The over-current check is enabled once preheat ends. The under-current check is enabled only in run mode, and it is looked at only at the moment the low-side gate drive turns off.

When any armed check trips, the latch sets. Both gate drives go low in the same cycle, and the block asserts a low-power request so that the oscillator stops. The latch holds against any later change on the flags. Only a shutdown request or a supply lockout clears it. While shutdown or lockout is high, the gates also stay off and the low-power request stays high. When shutdown returns low, the gates follow the sequencer again, and the sequencer restarts its full start sequence.

A sticky cause register records which checks have tripped. It clears together with the latch. All pins are plain control and status levels; there is no data stream, so no valid/ready handshake is used.

Top module: `hb_fault_guard`

## Requirements
- R1: After reset, fault_o is 0 and cause_o is 0. With shutdown_i and uvlo_i low, hi_drv_o equals hi_req_i, lo_drv_o equals lo_req_i, and low_power_o is 0.
- R2: The latch sets when oc_flag_i and oc_arm_i are both high on OC_CONFIRM consecutive clock edges (default 2). A single sampled edge of over-current has no effect on fault_o.
- R3: oc_flag_i has no effect while oc_arm_i is low. A low oc_arm_i also restarts the consecutive-sample count.
- R4: The under-current check sets the latch only on an edge where lo_req_i is sampled 0, the previous edge sampled it 1, and both uc_flag_i and uc_arm_i are high. uc_flag_i has no effect at any other edge.
- R5: ot_flag_i sets the latch on any edge where active_i is high. It has no effect while active_i is low.
- R6: From the cycle after the setting edge, fault_o is 1 and hi_drv_o and lo_drv_o are 0, whatever the requests are.
- R7: Once set, the latch holds until an edge samples shutdown_i or uvlo_i high, and that edge clears it. While either input is high, both drives are 0 at once (combinationally). low_power_o equals fault_o OR shutdown_i OR uvlo_i.
- R8: cause_o records tripped checks as sticky bits: bit 0 is over-current, bit 1 is under-current, bit 2 is over-temperature. Bits accumulate until the latch clears, and they clear on the same edge as the latch.
- R9: Clearing takes priority over setting. On an edge that samples shutdown_i or uvlo_i high, no check sets the latch, and the over-current count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oc_flag_i | input | 1 | Over-current comparator output |
| uc_flag_i | input | 1 | Under-current comparator output (current below the low threshold) |
| ot_flag_i | input | 1 | Over-temperature flag |
| oc_arm_i | input | 1 | Enables the over-current check (after preheat) |
| uc_arm_i | input | 1 | Enables the under-current check (run mode) |
| active_i | input | 1 | The sequencer is in an active mode |
| hi_req_i | input | 1 | High-side gate request from the oscillator |
| lo_req_i | input | 1 | Low-side gate request from the oscillator |
| shutdown_i | input | 1 | Shutdown request; clears the latch and holds the gates off |
| uvlo_i | input | 1 | Supply lockout; clears the latch and holds the gates off |
| hi_drv_o | output | 1 | Gated high-side drive |
| lo_drv_o | output | 1 | Gated low-side drive |
| fault_o | output | 1 | Latched fault |
| low_power_o | output | 1 | Stop-oscillator / low-power request |
| cause_o | output | 3 | Sticky fault cause bits |

## Verification
Each trip sets fault_o and cause_o one clock after the edge that samples the qualifying condition. For over-current, that edge is the second consecutive armed sample. For under-current, it is the first edge that sees lo_req_i low after seeing it high. Gate forcing from shutdown_i or uvlo_i acts in the same cycle, with no register in the path. The bench updates its reference model at each rising edge, using the inputs that were held since the previous falling edge. It compares every output at the next falling edge, just before new inputs are applied. Each scenario tags its checks with the requirement it exercises.

// File: rtl/hb_fault_pkg.sv
package hb_fault_pkg;
  localparam int CAUSE_W = 3;
  localparam int CAUSE_OC = 0;
  localparam int CAUSE_UC = 1;
  localparam int CAUSE_OT = 2;
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/hb_oc_filter.sv
module hb_oc_filter #(
  parameter int OC_CONFIRM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag_i,
  input  logic oc_arm_i,
  input  logic clear_i,
  output logic oc_trip_o
);
  localparam int CW = $clog2(OC_CONFIRM + 1);
  localparam logic [CW-1:0] LAST = CW'(OC_CONFIRM - 1);
  localparam logic [CW-1:0] SAT  = CW'(OC_CONFIRM);

  logic [CW-1:0] run_q;
  logic          hit;

  assign hit       = oc_flag_i && oc_arm_i;
  assign oc_trip_o = hit && !clear_i && (run_q >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (clear_i || !hit) run_q <= '0;
    else if (run_q != SAT)   run_q <= run_q + 1'b1;
  end

  generate
    if (OC_CONFIRM >= 2) begin : g_chk
      // R2
      oc_two_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip_o |-> $past(oc_flag_i && oc_arm_i && !clear_i));
    end
  endgenerate
endmodule

// File: rtl/hb_uc_sampler.sv
module hb_uc_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic uc_flag_i,
  input  logic uc_arm_i,
  input  logic lo_req_i,
  input  logic clear_i,
  output logic uc_trip_o
);
  logic lo_last_q;
  logic lo_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_last_q <= 1'b0;
    else        lo_last_q <= lo_req_i;
  end

  assign lo_fall   = lo_last_q && !lo_req_i;
  assign uc_trip_o = lo_fall && uc_flag_i && uc_arm_i && !clear_i;

  // R4
  uc_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uc_trip_o |-> ($past(lo_req_i) && !lo_req_i));
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch
  import hb_fault_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear_i,
  input  cause_t trip_i,
  output logic   fault_o,
  output cause_t cause_o
);
  logic   fault_q;
  cause_t cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= '0;
    end else if (clear_i) begin
      fault_q <= 1'b0;
      cause_q <= '0;
    end else begin
      if (|trip_i) fault_q <= 1'b1;
      cause_q <= cause_q | trip_i;
    end
  end

  assign fault_o = fault_q;
  assign cause_o = cause_q;

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !fault_q);
  // R7
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clear_i) |=> fault_q);
  // R8
  cause_with_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q == (cause_q != '0));
endmodule

// File: rtl/hb_fault_guard.sv
module hb_fault_guard
  import hb_fault_pkg::*;
#(
  parameter int OC_CONFIRM = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oc_flag_i,
  input  logic         uc_flag_i,
  input  logic         ot_flag_i,
  input  logic         oc_arm_i,
  input  logic         uc_arm_i,
  input  logic         active_i,
  input  logic         hi_req_i,
  input  logic         lo_req_i,
  input  logic         shutdown_i,
  input  logic         uvlo_i,
  output logic         hi_drv_o,
  output logic         lo_drv_o,
  output logic         fault_o,
  output logic         low_power_o,
  output logic [2:0]   cause_o
);
  logic   clear;
  logic   oc_trip, uc_trip, ot_trip;
  cause_t trips;
  logic   fault;
  cause_t cause;
  logic   kill;

  assign clear = shutdown_i || uvlo_i;

  hb_oc_filter #(.OC_CONFIRM(OC_CONFIRM)) u_oc (
    .clk(clk), .rst_n(rst_n), .oc_flag_i(oc_flag_i), .oc_arm_i(oc_arm_i),
    .clear_i(clear), .oc_trip_o(oc_trip));

  hb_uc_sampler u_uc (
    .clk(clk), .rst_n(rst_n), .uc_flag_i(uc_flag_i), .uc_arm_i(uc_arm_i),
    .lo_req_i(lo_req_i), .clear_i(clear), .uc_trip_o(uc_trip));

  assign ot_trip = ot_flag_i && active_i && !clear;

  always_comb begin
    trips = '0;
    trips[CAUSE_OC] = oc_trip;
    trips[CAUSE_UC] = uc_trip;
    trips[CAUSE_OT] = ot_trip;
  end

  hb_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .trip_i(trips),
    .fault_o(fault), .cause_o(cause));

  assign kill        = fault || clear;
  assign hi_drv_o    = hi_req_i && !kill;
  assign lo_drv_o    = lo_req_i && !kill;
  assign fault_o     = fault;
  assign low_power_o = kill;
  assign cause_o     = cause;

  // R6
  gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!hi_drv_o && !lo_drv_o));
  // R5
  ot_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_flag_i && active_i && !clear) |=> (fault_o && cause_o[CAUSE_OT]));
  // R9
  no_set_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cause_o == '0));
endmodule

// File: tb/hb_fault_guard_test.sv
module hb_fault_guard_test;
  localparam int CONF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_flag = 0, uc_flag = 0, ot_flag = 0, oc_arm = 0, uc_arm = 0, active = 0;
  logic hi_req = 0, lo_req = 0, shutdown = 0, uvlo = 0;
  logic hi_drv, lo_drv, fault, low_power;
  logic [2:0] cause;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  bit   m_fault = 0;
  bit [2:0] m_cause = 0;
  int   m_run = 0;
  bit   m_lo_last = 0;

  always #5 clk = ~clk;

  hb_fault_guard #(.OC_CONFIRM(CONF)) uut (
    .clk(clk), .rst_n(rst_n), .oc_flag_i(oc_flag), .uc_flag_i(uc_flag),
    .ot_flag_i(ot_flag), .oc_arm_i(oc_arm), .uc_arm_i(uc_arm), .active_i(active),
    .hi_req_i(hi_req), .lo_req_i(lo_req), .shutdown_i(shutdown), .uvlo_i(uvlo),
    .hi_drv_o(hi_drv), .lo_drv_o(lo_drv), .fault_o(fault),
    .low_power_o(low_power), .cause_o(cause));

  // reference model, updated on each rising edge from held inputs
  always @(posedge clk) begin
    if (rst_n) begin
      bit clr;
      bit [2:0] t;
      clr = shutdown | uvlo;
      t = 3'b000;
      if (clr) begin
        m_run = 0;
      end else if (oc_flag && oc_arm) begin
        if (m_run >= CONF - 1) t[0] = 1;
        if (m_run < CONF) m_run++;
      end else begin
        m_run = 0;
      end
      if (!clr && uc_flag && uc_arm && m_lo_last && !lo_req) t[1] = 1;
      if (!clr && ot_flag && active) t[2] = 1;
      if (clr) begin
        m_fault = 0; m_cause = 0;
      end else begin
        if (t != 0) m_fault = 1;
        m_cause = m_cause | t;
      end
      m_lo_last = lo_req;
    end
  end

  task automatic expect_bit(string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit clr;
    clr = shutdown | uvlo;
    expect_bit("fault_o", fault, m_fault);
    expect_bit("hi_drv_o", hi_drv, hi_req & ~m_fault & ~clr);
    expect_bit("lo_drv_o", lo_drv, lo_req & ~m_fault & ~clr);
    expect_bit("low_power_o", low_power, m_fault | clr);
    checks++;
    if (cause !== m_cause) begin
      errors++;
      $display("FAIL %s cause_o actual=%0b expected=%0b at %0t", tag, cause, m_cause, $time);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic clear_latch();
    shutdown = 1; tick(1);
    shutdown = 0; tick(1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1";
        hi_req = 1; lo_req = 0; tick(1);
        expect_bit("reset fault_o", fault, 0);
        hi_req = 0; lo_req = 1; tick(2);

        tag = "R2"; // single over-current sample ignored, two consecutive trip
        oc_arm = 1; oc_flag = 1; tick(1);
        oc_flag = 0; tick(2);
        expect_bit("single oc no trip", fault, 0);
        oc_flag = 1; tick(1);
        expect_bit("one sample", fault, 0);
        tick(1);
        expect_bit("two samples trip", fault, 1);
        tag = "R6";
        hi_req = 1; lo_req = 1; tick(2);
        expect_bit("hi forced low", hi_drv, 0);
        tag = "R7"; // latch holds after flag drops
        oc_flag = 0; tick(4);
        expect_bit("held", fault, 1);
        clear_latch();
        expect_bit("cleared", fault, 0);

        tag = "R3"; // unarmed over-current ignored
        oc_arm = 0; oc_flag = 1; tick(5);
        expect_bit("unarmed oc", fault, 0);
        oc_arm = 1; tick(1); oc_arm = 0; tick(1); oc_arm = 1; tick(1);
        expect_bit("arm gap restarts count", fault, 0);
        oc_flag = 0; oc_arm = 0; tick(1);

        tag = "R4"; // under-current only at low-side falling edge
        uc_arm = 1; uc_flag = 1; lo_req = 1; tick(3);
        expect_bit("uc while lo high", fault, 0);
        lo_req = 0; tick(1);
        expect_bit("uc at fall", fault, 1);
        expect_bit("uc cause", cause[1], 1);
        clear_latch();
        lo_req = 1; uc_flag = 0; tick(1);
        lo_req = 0; tick(1);
        uc_flag = 1; tick(3);
        expect_bit("uc after fall ignored", fault, 0);
        uc_arm = 0; lo_req = 1; tick(1); lo_req = 0; tick(1);
        expect_bit("uc unarmed at fall", fault, 0);
        uc_flag = 0;

        tag = "R5"; // over-temperature
        ot_flag = 1; active = 0; tick(3);
        expect_bit("ot inactive", fault, 0);
        active = 1; tick(1);
        expect_bit("ot active", fault, 1);
        tag = "R8"; // sticky accumulation
        ot_flag = 0; oc_arm = 1; oc_flag = 1; tick(3);
        expect_bit("cause oc added", cause[0], 1);
        expect_bit("cause ot kept", cause[2], 1);
        oc_flag = 0;
        uvlo = 1; tick(1);
        expect_bit("uvlo clears cause", cause[2], 0);

        tag = "R9"; // clear beats set
        ot_flag = 1; oc_flag = 1; tick(4);
        expect_bit("no set during uvlo", fault, 0);
        uvlo = 0; ot_flag = 0; tick(1);
        expect_bit("oc count restarted", fault, 0);
        tick(1);
        expect_bit("oc after restart", fault, 1);
        oc_flag = 0;
        tag = "R7";
        shutdown = 1; hi_req = 1; lo_req = 1; tick(3);
        expect_bit("sd holds gates off", lo_drv, 0);
        shutdown = 0; tick(2);
        expect_bit("gates resume", lo_drv, 1);
        tag = "R1";
        tick(2);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule